// File: doc/BRIEF.md
# AES3 Subframe Framer with Block Sync

This block turns parallel audio samples and their per-subframe validity, user and channel-status bits into a serial AES3 transmit line. It runs from an oversampling master clock. A sequencer counts half-cells, subframes and frames. For each subframe it chooses the preamble, packs the 32 time slots with even parity, and biphase-mark codes them onto `line_o`. Each input word passes through a fixed pipeline of four subframes before it is sent.

The block samples one input word at every subframe start and marks that clock with `take_o`. It also drives a word-rate clock, `word_o`. In stereo mode `word_o` runs at the frame rate. In mono mode it runs at twice the frame rate. Its polarity is selectable.

Channel-status blocks are 192 frames long. Block timing can be set from outside with a block-start input, or reported on a block-start output. With the input selected, a level held high long enough aborts the current subframe and starts a fresh frame and channel-status block. With the output selected, the block flags each subframe that opens a block.

Top module: `aes3_framer`

## Requirements
- R1: A subframe lasts 64 half-cells of HALF_DIV master clocks each. `take_o` is high for exactly one clock in the last clock of every subframe. The input word present in that clock is captured, and the next subframe starts at the following edge. Subframes alternate between channel A and channel B.
- R2: Slots 0 to 3 hold the preamble. Slots 4 to 27 hold the 24-bit audio word, least significant bit first. A narrower AUDIO_W sample is left-justified, with zeros below it. Slot 28 is validity, slot 29 is user, slot 30 is channel status. Slot 31 is a parity bit that makes the count of ones in slots 4 to 31 even.
- R3: Each data slot is one bit cell of two half-cells. The line toggles at the start of every cell, and toggles again at mid-cell when the bit is 1.
- R4: Preambles span 8 half-cells. With the line low before them, their levels are 11101000 for Z (block start), 11100010 for X (channel A) and 11100100 for Y (channel B), leftmost first. They are inverted when the line was high.
- R5: A channel-status block is 192 frames. The channel-A subframe of frame 0 carries Z. Every other channel-A subframe carries X and every channel-B subframe carries Y. The frame count wraps from 191 to 0.
- R6: A word captured at one `take_o` is sent in the subframe that starts four `take_o` pulses later. The first four subframes after reset carry all-zero data slots.
- R7: With `bs_out_en_i` low, `bs_i` passes through a two-flop synchroniser. If it is sampled high on 4 consecutive edges (more than 3 clocks), `take_o` is asserted in the clock after the fifth edge from the first high sample, aborting the current subframe. The next subframe is a Z subframe of frame 0. Holding `bs_i` high longer gives only one restart.
- R8: A high level on `bs_i` lasting 3 clocks or fewer causes no restart. `bs_i` has no effect while `bs_out_en_i` is high.
- R9: With `bs_out_en_i` high, `bs_o` is high for the whole of every Z subframe and low otherwise. With `bs_out_en_i` low, `bs_o` is low.
- R10: With `wpol_i` low, `word_o` is high during channel-A subframes in stereo mode (`mono_i` low). In mono mode it is high during the first 32 half-cells of every subframe. `wpol_i` high inverts `word_o`.
- R11: During and after reset, `line_o` is low and `bs_o` is low. The first subframe period is idle, with no line transitions, and then a Z subframe begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| audio_i | input | AUDIO_W | Audio sample for the next captured subframe |
| valid_i | input | 1 | Validity bit for the captured subframe |
| user_i | input | 1 | User bit for the captured subframe |
| chan_i | input | 1 | Channel-status bit for the captured subframe |
| mono_i | input | 1 | Word-rate clock at twice the frame rate when high |
| wpol_i | input | 1 | Inverts the word-rate clock |
| bs_out_en_i | input | 1 | Selects reporting block starts (1) or accepting them (0) |
| bs_i | input | 1 | External block-start request |
| bs_o | output | 1 | High throughout each block-start subframe |
| take_o | output | 1 | Input word captured at the end of this clock |
| word_o | output | 1 | Word-rate clock |
| line_o | output | 1 | Biphase-mark coded AES3 line |

## Verification
The hardest state to reach from the ports is a forced restart that lands mid-subframe. The line level at that moment is arbitrary and the pipeline still holds older words, so the Z pattern must come out inverted or not, depending on history. The stimulus sends block-start pulses of 2, 3, 4 and 20 clocks at unrelated offsets within subframes, and sends one more while the pin is set as an output. A cycle-level reference model follows the line through all of these. One run also crosses a full 192-frame wrap, so the naturally occurring Z can be timed against the reported block-start output.

// File: rtl/aes3_pkg.sv
package aes3_pkg;

   localparam int SLOTS      = 32;
   localparam int HALVES     = 2 * SLOTS;
   localparam int DATA_SLOTS = 28;
   localparam int FULL_W     = 24;

   typedef enum logic [1:0] {
      PRE_X = 2'd0,
      PRE_Y = 2'd1,
      PRE_Z = 2'd2
   } pre_e;

   typedef struct packed {
      logic [FULL_W-1:0] audio;
      logic              v;
      logic              u;
      logic              c;
   } sf_word_t;

   // Preamble as a toggle mask, bit i = transition at start of half-cell i
   function automatic logic [7:0] pre_toggles(pre_e p);
      case (p)
         PRE_X:   return 8'hC9;
         PRE_Y:   return 8'h69;
         default: return 8'h39;
      endcase
   endfunction

   function automatic logic [HALVES-1:0] make_toggles(sf_word_t w, pre_e p);
      logic [DATA_SLOTS-1:0] bits;
      logic [HALVES-1:0]     t;
      bits = {1'b0, w.c, w.u, w.v, w.audio};
      bits[DATA_SLOTS-1] = ^bits[DATA_SLOTS-2:0];
      t = '0;
      t[7:0] = pre_toggles(p);
      for (int i = 0; i < DATA_SLOTS; i++) begin
         t[8 + 2*i]     = 1'b1;
         t[8 + 2*i + 1] = bits[i];
      end
      return t;
   endfunction

endpackage

// File: rtl/aes3_bsync.sv
module aes3_bsync #(
   parameter int SYNC_MIN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic bs_i,
   output logic restart_o
);
   localparam int CW  = $clog2(SYNC_MIN + 2);
   localparam int SAT = SYNC_MIN + 1;

   logic          s1_q, s2_q;
   logic [CW-1:0] run_q;
   logic          fire_q;

   generate
      if (SYNC_MIN < 1) begin : g_bad_min
         $error("SYNC_MIN must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q   <= 1'b0;
         s2_q   <= 1'b0;
         run_q  <= '0;
         fire_q <= 1'b0;
      end else begin
         s1_q   <= bs_i;
         s2_q   <= s1_q;
         fire_q <= enable_i && s2_q && (run_q == CW'(SYNC_MIN));
         if (!enable_i || !s2_q)
            run_q <= '0;
         else if (run_q != CW'(SAT))
            run_q <= run_q + CW'(1);
      end
   end

   assign restart_o = fire_q;

   // R7
   restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |=> !restart_o);

endmodule

// File: rtl/aes3_seq.sv
module aes3_seq
   import aes3_pkg::*;
#(
   parameter int HALF_DIV     = 1,
   parameter int BLOCK_FRAMES = 192,
   localparam int FW          = $clog2(BLOCK_FRAMES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart_i,
   output logic          load_o,
   output logic          half_edge_o,
   output logic [5:0]    hc_o,
   output logic [FW-1:0] frame_o,
   output logic          sub_o,
   output pre_e          pre_o
);
   logic [5:0]    hc_q;
   logic [FW-1:0] frame_q, frame_n;
   logic          sub_q, sub_n;
   logic          half_edge;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (BLOCK_FRAMES < 2) begin : g_bad_blk
         $error("BLOCK_FRAMES must be at least 2");
      end
      if (HALF_DIV == 1) begin : g_nodiv
         assign half_edge = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(HALF_DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n || load_o || half_edge)
               div_q <= '0;
            else
               div_q <= div_q + DW'(1);
         end
         assign half_edge = (div_q == DW'(HALF_DIV - 1));
      end
   endgenerate

   assign load_o = restart_i || (half_edge && hc_q == 6'(HALVES - 1));

   always_comb begin
      if (restart_i) begin
         frame_n = '0;
         sub_n   = 1'b0;
      end else if (sub_q) begin
         sub_n   = 1'b0;
         frame_n = (frame_q == FW'(BLOCK_FRAMES - 1)) ? '0 : frame_q + FW'(1);
      end else begin
         sub_n   = 1'b1;
         frame_n = frame_q;
      end
      if (sub_n)
         pre_o = PRE_Y;
      else if (frame_n == '0)
         pre_o = PRE_Z;
      else
         pre_o = PRE_X;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hc_q    <= '0;
         sub_q   <= 1'b1;
         frame_q <= FW'(BLOCK_FRAMES - 1);
      end else if (load_o) begin
         hc_q    <= '0;
         sub_q   <= sub_n;
         frame_q <= frame_n;
      end else if (half_edge) begin
         hc_q    <= hc_q + 6'd1;
      end
   end

   assign half_edge_o = half_edge;
   assign hc_o        = hc_q;
   assign frame_o     = frame_q;
   assign sub_o       = sub_q;

   // R5
   frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_o < FW'(BLOCK_FRAMES));

   // R7
   restart_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (frame_o == '0 && !sub_o && hc_o == '0));

   // R1
   alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_o && !restart_i) |=> (sub_o != $past(sub_o)));

endmodule

// File: rtl/aes3_txpipe.sv
module aes3_txpipe
   import aes3_pkg::*;
#(
   parameter int PIPE_SUBS = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load_i,
   input  logic     half_edge_i,
   input  sf_word_t word_i,
   input  pre_e     pre_i,
   output logic     line_o
);
   sf_word_t          stg_q [PIPE_SUBS];
   logic [HALVES-1:0] sh_q;
   logic [HALVES-1:0] tog_new;
   logic              line_q;

   generate
      if (PIPE_SUBS < 1) begin : g_bad_pipe
         $error("PIPE_SUBS must be at least 1");
      end
      for (genvar g = 0; g < PIPE_SUBS; g++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n)
               stg_q[g] <= '0;
            else if (load_i) begin
               if (g == 0)
                  stg_q[g] <= word_i;
               else
                  stg_q[g] <= stg_q[(g == 0) ? 0 : g - 1];
            end
         end
      end
   endgenerate

   assign tog_new = make_toggles(stg_q[PIPE_SUBS-1], pre_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         line_q <= 1'b0;
      end else if (load_i) begin
         sh_q   <= tog_new;
         line_q <= line_q ^ tog_new[0];
      end else if (half_edge_i) begin
         sh_q   <= sh_q >> 1;
         line_q <= line_q ^ sh_q[1];
      end
   end

   assign line_o = line_q;

   // R2
   parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> ($countones(sh_q) % 2 == 0));

endmodule

// File: rtl/aes3_framer.sv
module aes3_framer
   import aes3_pkg::*;
#(
   parameter int HALF_DIV     = 1,
   parameter int AUDIO_W      = 24,
   parameter int BLOCK_FRAMES = 192,
   parameter int PIPE_SUBS    = 4,
   parameter int SYNC_MIN     = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AUDIO_W-1:0] audio_i,
   input  logic               valid_i,
   input  logic               user_i,
   input  logic               chan_i,
   input  logic               mono_i,
   input  logic               wpol_i,
   input  logic               bs_out_en_i,
   input  logic               bs_i,
   output logic               bs_o,
   output logic               take_o,
   output logic               word_o,
   output logic               line_o
);
   localparam int FW = $clog2(BLOCK_FRAMES);

   logic          restart;
   logic          load;
   logic          half_edge;
   logic [5:0]    hc;
   logic [FW-1:0] frame;
   logic          sub;
   pre_e          pre;
   sf_word_t      word_in;
   logic [FULL_W-1:0] audio_full;

   generate
      if (AUDIO_W < 1 || AUDIO_W > FULL_W) begin : g_bad_w
         $error("AUDIO_W must lie in 1..24");
      end
      if (AUDIO_W == FULL_W) begin : g_full
         assign audio_full = audio_i;
      end else begin : g_just
         assign audio_full = {audio_i, {(FULL_W - AUDIO_W){1'b0}}};
      end
   endgenerate

   assign word_in = '{audio: audio_full, v: valid_i, u: user_i, c: chan_i};

   aes3_bsync #(.SYNC_MIN(SYNC_MIN)) u_bsync (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable_i  (!bs_out_en_i),
      .bs_i      (bs_i),
      .restart_o (restart)
   );

   aes3_seq #(.HALF_DIV(HALF_DIV), .BLOCK_FRAMES(BLOCK_FRAMES)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart_i   (restart),
      .load_o      (load),
      .half_edge_o (half_edge),
      .hc_o        (hc),
      .frame_o     (frame),
      .sub_o       (sub),
      .pre_o       (pre)
   );

   aes3_txpipe #(.PIPE_SUBS(PIPE_SUBS)) u_pipe (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load),
      .half_edge_i (half_edge),
      .word_i      (word_in),
      .pre_i       (pre),
      .line_o      (line_o)
   );

   assign take_o = load;
   assign bs_o   = bs_out_en_i && !sub && (frame == '0);
   assign word_o = wpol_i ^ (mono_i ? !hc[5] : !sub);

   // R9
   bs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && bs_out_en_i && bs_o) |=> !bs_o);

endmodule

// File: tb/test_aes3_framer.sv
module test_aes3_framer;
   localparam int H  = 1;
   localparam int SP = 64 * H;
   localparam int BF = 192;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] audio_i = '0;
   logic        valid_i = 0, user_i = 0, chan_i = 0;
   logic        mono_i = 0, wpol_i = 0, bs_out_en_i = 0, bs_i = 0;
   logic        bs_o, take_o, word_o, line_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   aes3_framer i_aes3_framer (
      .clk(clk), .rst_n(rst_n), .audio_i(audio_i), .valid_i(valid_i),
      .user_i(user_i), .chan_i(chan_i), .mono_i(mono_i), .wpol_i(wpol_i),
      .bs_out_en_i(bs_out_en_i), .bs_i(bs_i), .bs_o(bs_o), .take_o(take_o),
      .word_o(word_o), .line_o(line_o)
   );

   // behavioural reference model
   int          m_s1, m_s2, m_run, m_fire;
   int          m_pos, m_frame, m_sub, m_line;
   bit          m_tog [64];
   logic [26:0] m_q [$];

   task automatic build(input logic [26:0] w, input int kind);
      bit bits [28];
      int ones = 0;
      for (int i = 0; i < 24; i++) bits[i] = w[3 + i];
      bits[24] = w[2]; bits[25] = w[1]; bits[26] = w[0];
      for (int i = 0; i < 27; i++) ones += bits[i];
      bits[27] = ones % 2;
      // levels from low: Z 11101000, X 11100010, Y 11100100 (0=Z,1=X,2=Y)
      for (int i = 0; i < 8; i++) begin
         int lv, pv;
         lv = (kind == 0) ? ((8'b11101000 >> (7 - i)) & 1) :
              (kind == 1) ? ((8'b11100010 >> (7 - i)) & 1) :
                            ((8'b11100100 >> (7 - i)) & 1);
         pv = (i == 0) ? 0 : ((kind == 0) ? ((8'b11101000 >> (8 - i)) & 1) :
              (kind == 1) ? ((8'b11100010 >> (8 - i)) & 1) :
                            ((8'b11100100 >> (8 - i)) & 1));
         m_tog[i] = (lv != pv);
      end
      for (int s = 0; s < 28; s++) begin
         m_tog[8 + 2*s]     = 1;
         m_tog[8 + 2*s + 1] = bits[s];
      end
   endtask

   task automatic model_reset();
      m_s1 = 0; m_s2 = 0; m_run = 0; m_fire = 0;
      m_pos = 0; m_frame = BF - 1; m_sub = 1; m_line = 0;
      for (int i = 0; i < 64; i++) m_tog[i] = 0;
      m_q.delete();
      for (int i = 0; i < 4; i++) m_q.push_front(27'd0);
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         int load, nfire, en;
         en    = !bs_out_en_i;
         load  = m_fire || (m_pos == SP - 1);
         nfire = en && m_s2 && (m_run == 3);
         if (!en || !m_s2) m_run = 0; else if (m_run < 4) m_run++;
         m_s2 = m_s1; m_s1 = bs_i;
         if (load) begin
            logic [26:0] tx;
            m_q.push_front({audio_i, valid_i, user_i, chan_i});
            tx = m_q.pop_back();
            if (m_fire) begin m_frame = 0; m_sub = 0; end
            else if (m_sub == 1) begin
               m_sub = 0; m_frame = (m_frame == BF - 1) ? 0 : m_frame + 1;
            end else m_sub = 1;
            build(tx, (m_sub == 1) ? 2 : (m_frame == 0 ? 0 : 1));
            m_pos = 0;
            m_line ^= m_tog[0];
         end else begin
            m_pos++;
            if (m_pos % H == 0) m_line ^= m_tog[m_pos / H];
         end
         m_fire = nfire;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
      end
   endtask

   bit cmp_on = 0;
   always @(negedge clk) if (cmp_on) begin
      chk("R2/R3/R4/R6 line_o", line_o, m_line);
      chk("R1/R7/R8 take_o", take_o, (m_fire || m_pos == SP - 1));
      chk("R10 word_o", word_o, wpol_i ^ (mono_i ? ((m_pos / H) < 32) : (m_sub == 0)));
      chk("R9 bs_o", bs_o, bs_out_en_i && m_sub == 0 && m_frame == 0);
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         if (i % 13 == 0) begin
            audio_i = 24'($urandom); valid_i = 1'($urandom);
            user_i = 1'($urandom); chan_i = 1'($urandom);
         end
      end
   endtask

   task automatic pulse(input int n);
      @(negedge clk); #1 bs_i = 1;
      step(n);
      bs_i = 0;
   endtask

   int watchdog_hit = 0;
   initial begin
      #(2_000_000 * 10);
      watchdog_hit = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int t0, rises;
      step(3);
      // R11 reset state
      chk("R11 line low in reset", line_o, 0);
      chk("R11 bs_o low in reset", bs_o, 0);
      chk("R11 take idle in reset", take_o, 0);
      @(negedge clk); #1 rst_n = 1; cmp_on = 1;
      step(SP - 2);
      chk("R11 line idle first subframe", line_o, 0);
      step(3 * SP + 17);
      pulse(2);  step(150);           // R8 short glitch
      pulse(3);  step(211);           // R8 three clocks
      pulse(4);  step(300);           // R7 restart
      pulse(20); step(500);           // R7 single restart when held
      mono_i = 1; step(700);          // R10 mono
      wpol_i = 1; step(400);          // R10 polarity
      mono_i = 0; step(400);
      wpol_i = 0;
      bs_out_en_i = 1; step(9);
      pulse(30); step(300);           // R8 ignored as output
      // R5 block length via reported block starts
      rises = 0; t0 = 0;
      for (int c = 0; c < 2 * BF * 2 * SP + 10 && rises < 2; c++) begin
         @(negedge clk);
         if (bs_o && take_o == 0 && m_pos == 0) begin
            rises++;
            if (rises == 1) t0 = c; else chk("R5 block period", c - t0, BF * 2 * SP);
         end
      end
      chk("R5 two block starts seen", rises, 2);
      bs_out_en_i = 0; step(40);
      pulse(5); step(2 * SP);         // R7 restart after mode change
      cmp_on = 0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule